// File: doc/BRIEF.md
# Control-Dependent Rise Timing Monitor

This block is a synthesizable runtime checker for a digitized timing relationship. Three comparator results reach it on every clock: a phase-sign bit that is high when the phase is non-negative, a bit that is high when omega is at or above its threshold, and a 2-bit control code. Once the monitor is armed by a non-negative phase, it takes the required quiet length from the control code. Omega must then stay low for exactly that many samples and must rise within a short window after that. The verdict is a one-cycle pass pulse, or a one-cycle fail pulse that carries a reason code. After any verdict, the monitor waits for the phase to turn negative before it can arm again.

All timing is counted in clock samples. Each hold length and the window length are parameters. The control code is taken only at the arming sample, so a code that changes during a check does not change the running check.

Top module: `rise_window_mon`

## Requirements
- R1: A synchronous active-high `rst` puts the monitor in the idle state, where it waits for `phase_nonneg`. In the cycle after `rst` is sampled high, `pass_o` and `fail_o` are 0 and `fail_why` is 2'b00.
- R2: In the idle state, a sample with `phase_nonneg`=1 arms the monitor, and `ctrl_code` is taken from that same sample. A change of `ctrl_code` later in the check has no effect on it.
- R3: The hold length is 1375 samples for code 1, 1315 for code 2 and 1255 for code 3. These are the samples that directly follow the arming sample.
- R4: Code 0 starts no check. It produces no pulse, and the monitor waits for `phase_nonneg`=0.
- R5: If `omega_hi` is 1 on any hold sample, `fail_o` pulses in the next cycle with `fail_why`=2'b01 (early). This includes the last hold sample.
- R6: If `omega_hi` is 1 on one of the 11 samples that follow the hold, `pass_o` pulses in the next cycle. These are window positions 0 to 10.
- R7: If `omega_hi` is 0 on all 11 window samples, `fail_o` pulses in the cycle after the last of them, with `fail_why`=2'b10 (late).
- R8: After a verdict, or after code 0, the monitor does not arm again until it has sampled `phase_nonneg`=0. A drop of `phase_nonneg` during a running check is ignored.
- R9: `pass_o` and `fail_o` are single-cycle pulses, and they are never high together. `fail_why` is 2'b00 whenever `fail_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| phase_nonneg | input | 1 | 1 when the phase is greater than or equal to zero |
| omega_hi | input | 1 | 1 when omega is at or above its threshold |
| ctrl_code | input | 2 | Control code that selects the hold length |
| pass_o | output | 1 | One-cycle pulse: the rise came inside the window |
| fail_o | output | 1 | One-cycle pulse: the rise came early or late |
| fail_why | output | 2 | 2'b01 early, 2'b10 late, 2'b00 when no fail |

## Verification
Two events can fall on one sample: the hold count reaching its end, and omega rising. The early fail must win on that sample. The bench provokes this by raising omega on the last hold sample (1374 low samples after arming with code 1) and expects reason 2'b01. A rise one sample later must pass. The window edge is tested the same way: a rise at window position 10 must pass, and one sample later the late fail must fire without any rise at all. A behavioural model checks every cycle, and pulse counts per scenario confirm the outcome.

// File: rtl/rwm_pkg.sv
package rwm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_WIN   = 2'd2,
    ST_REARM = 2'd3
  } rwm_state_e;

  typedef enum logic [1:0] {
    WHY_NONE  = 2'b00,
    WHY_EARLY = 2'b01,
    WHY_LATE  = 2'b10
  } rwm_why_e;
endpackage

// File: rtl/rwm_hold_sel.sv
module rwm_hold_sel #(
  parameter int HOLD_C1 = 1375,
  parameter int HOLD_C2 = 1315,
  parameter int HOLD_C3 = 1255,
  parameter int CNT_W   = 11
) (
  input  logic [1:0]       code,
  output logic [CNT_W-1:0] hold_m1,
  output logic             code_ok
);
  // Each entry is the hold length minus one, ready to load the down counter.
  localparam logic [CNT_W-1:0] LD1 = CNT_W'(HOLD_C1 - 1);
  localparam logic [CNT_W-1:0] LD2 = CNT_W'(HOLD_C2 - 1);
  localparam logic [CNT_W-1:0] LD3 = CNT_W'(HOLD_C3 - 1);

  always_comb begin
    code_ok = 1'b1;
    unique case (code)
      2'd1:    hold_m1 = LD1;
      2'd2:    hold_m1 = LD2;
      2'd3:    hold_m1 = LD3;
      default: begin
        hold_m1 = '0;
        code_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rwm_down_cnt.sv
module rwm_down_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/rise_window_mon.sv
module rise_window_mon #(
  parameter int HOLD_C1  = 1375,
  parameter int HOLD_C2  = 1315,
  parameter int HOLD_C3  = 1255,
  parameter int RISE_WIN = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       phase_nonneg,
  input  logic       omega_hi,
  input  logic [1:0] ctrl_code,
  output logic       pass_o,
  output logic       fail_o,
  output logic [1:0] fail_why
);
  import rwm_pkg::*;

  localparam int MAX_A = (HOLD_C1 > HOLD_C2) ? HOLD_C1 : HOLD_C2;
  localparam int MAX_B = (HOLD_C3 > RISE_WIN) ? HOLD_C3 : RISE_WIN;
  localparam int MAX_V = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_V + 1);
  localparam logic [CNT_W-1:0] WIN_LD = CNT_W'(RISE_WIN);

  rwm_state_e       state_q, state_d;
  logic [CNT_W-1:0] hold_m1;
  logic             code_ok;
  logic             cnt_load, cnt_dec, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic             pass_d, fail_d;
  rwm_why_e         why_d;

  rwm_hold_sel #(
    .HOLD_C1(HOLD_C1), .HOLD_C2(HOLD_C2), .HOLD_C3(HOLD_C3), .CNT_W(CNT_W)
  ) sel_i (
    .code(ctrl_code), .hold_m1(hold_m1), .code_ok(code_ok)
  );

  rwm_down_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .zero(cnt_zero)
  );

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = hold_m1;
    cnt_dec  = 1'b0;
    pass_d   = 1'b0;
    fail_d   = 1'b0;
    why_d    = WHY_NONE;
    unique case (state_q)
      ST_IDLE: begin
        if (phase_nonneg) begin
          if (code_ok) begin
            cnt_load = 1'b1;
            state_d  = ST_HOLD;
          end else begin
            state_d  = ST_REARM;
          end
        end
      end
      ST_HOLD: begin
        // A rise wins over hold expiry on the same sample.
        if (omega_hi) begin
          fail_d  = 1'b1;
          why_d   = WHY_EARLY;
          state_d = ST_REARM;
        end else if (cnt_zero) begin
          cnt_load = 1'b1;
          cnt_val  = WIN_LD;
          state_d  = ST_WIN;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_WIN: begin
        if (omega_hi) begin
          pass_d  = 1'b1;
          state_d = ST_REARM;
        end else if (cnt_zero) begin
          fail_d  = 1'b1;
          why_d   = WHY_LATE;
          state_d = ST_REARM;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      default: begin
        if (!phase_nonneg) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pass_o   <= 1'b0;
      fail_o   <= 1'b0;
      fail_why <= WHY_NONE;
    end else begin
      state_q  <= state_d;
      pass_o   <= pass_d;
      fail_o   <= fail_d;
      fail_why <= why_d;
    end
  end
endmodule

// File: rtl/rwm_chk.sv
module rwm_chk (
  input logic       clk,
  input logic       rst,
  input logic       omega_hi,
  input logic       pass_o,
  input logic       fail_o,
  input logic [1:0] fail_why
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!pass_o && !fail_o && fail_why == 2'b00));

  // R5
  early_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_o && fail_why == 2'b01) |-> $past(omega_hi));

  // R6
  pass_cause_chk: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> $past(omega_hi));

  // R7
  late_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_o && fail_why == 2'b10) |-> !$past(omega_hi));

  // R9
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass_o && fail_o));

  // R9
  why_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !fail_o |-> fail_why == 2'b00);

  // R9
  pass_single_chk: assert property (@(posedge clk) disable iff (rst)
    pass_o |=> !pass_o);

  // R9
  fail_single_chk: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> !fail_o);
endmodule

bind rise_window_mon rwm_chk chk_i (
  .clk(clk), .rst(rst), .omega_hi(omega_hi),
  .pass_o(pass_o), .fail_o(fail_o), .fail_why(fail_why)
);

// File: tb/rise_window_mon_tb_top.sv
`timescale 1ns/1ps
module rise_window_mon_tb_top;
  localparam int WIN = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       phase_nonneg = 1'b0;
  logic       omega_hi = 1'b0;
  logic [1:0] ctrl_code = 2'd0;
  logic       pass_o, fail_o;
  logic [1:0] fail_why;

  int vectors = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference model
  int  m_mode = 0;          // 0 idle, 1 hold, 2 window, 3 wait-negative
  int  m_need = 0;
  int  m_seen = 0;
  bit  e_pass = 0, e_fail = 0;
  int  e_why = 0;

  // per-scenario pulse tallies
  int n_pass = 0, n_fail = 0, last_why = 0;

  always #4 clk = ~clk;

  rise_window_mon dut_i (
    .clk(clk), .rst(rst), .phase_nonneg(phase_nonneg), .omega_hi(omega_hi),
    .ctrl_code(ctrl_code), .pass_o(pass_o), .fail_o(fail_o), .fail_why(fail_why)
  );

  function automatic int hold_len(int c);
    if (c == 1) return 1375;
    if (c == 2) return 1315;
    if (c == 3) return 1255;
    return 0;
  endfunction

  always @(posedge clk) begin
    e_pass = 0; e_fail = 0; e_why = 0;
    if (rst) m_mode = 0;
    else if (m_mode == 0) begin
      if (phase_nonneg) begin
        m_need = hold_len(int'(ctrl_code));
        m_seen = 0;
        m_mode = (m_need == 0) ? 3 : 1;
      end
    end else if (m_mode == 1) begin
      if (omega_hi) begin e_fail = 1; e_why = 1; m_mode = 3; end
      else begin
        m_seen++;
        if (m_seen == m_need) begin m_mode = 2; m_seen = 0; end
      end
    end else if (m_mode == 2) begin
      if (omega_hi) begin e_pass = 1; m_mode = 3; end
      else if (m_seen == WIN) begin e_fail = 1; e_why = 2; m_mode = 3; end
      else m_seen++;
    end else begin
      if (!phase_nonneg) m_mode = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (pass_o !== e_pass || fail_o !== e_fail || int'(fail_why) != e_why) begin
        errors++;
        $display("FAIL %s cycle %0d: pass/fail/why actual %b/%b/%0d expected %0b/%0b/%0d",
                 cur_req, cyc, pass_o, fail_o, fail_why, e_pass, e_fail, e_why);
      end
      if (pass_o) n_pass++;
      if (fail_o) begin n_fail++; last_why = int'(fail_why); end
    end
  end

  task automatic finish_up();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_up();
    end
  end

  task automatic check_eq(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Arm with code, wait `low` quiet samples after arming, then raise omega.
  task automatic run_case(string tag, int code, int low, int alt_code, bit glitch,
                          int exp_p, int exp_f, int exp_w);
    cur_req = tag;
    n_pass = 0; n_fail = 0; last_why = 0;
    @(negedge clk);
    ctrl_code = 2'(code);
    omega_hi = 0;
    phase_nonneg = 1;
    @(negedge clk);                 // arming sample taken at preceding edge
    if (alt_code >= 0) ctrl_code = 2'(alt_code);
    for (int i = 0; i < low; i++) begin
      if (glitch && i == 100) phase_nonneg = 0;
      if (glitch && i == 106) phase_nonneg = 1;
      @(negedge clk);
    end
    omega_hi = 1;
    repeat (20) @(negedge clk);     // phase still high: must not re-arm (R8)
    phase_nonneg = 0;
    omega_hi = 0;
    repeat (3) @(negedge clk);
    check_eq(tag, "pass pulses", n_pass, exp_p);
    check_eq(tag, "fail pulses", n_fail, exp_f);
    check_eq(tag, "fail reason", last_why, exp_w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    check_eq("R1", "pass after reset", int'(pass_o), 0);
    check_eq("R1", "reason after reset", int'(fail_why), 0);

    run_case("R3",  1, 1375, -1, 0, 1, 0, 0);   // code 1 rise at window pos 0
    run_case("R5",  1, 1374, -1, 0, 0, 1, 1);   // rise on last hold sample
    run_case("R6",  2, 1325, -1, 0, 1, 0, 0);   // rise at window pos 10
    run_case("R7",  2, 1326, -1, 0, 0, 1, 2);   // one sample too late
    run_case("R5",  3, 0,    -1, 0, 0, 1, 1);   // rise on first hold sample
    run_case("R3",  3, 1255, -1, 0, 1, 0, 0);
    run_case("R7",  3, 1300, -1, 0, 0, 1, 2);
    run_case("R4",  0, 40,   -1, 0, 0, 0, 0);   // code 0: no check
    run_case("R2",  1, 1300,  3, 0, 0, 1, 1);   // code change ignored
    run_case("R8",  2, 1320, -1, 1, 1, 0, 0);   // phase dip during hold

    // R1: reset in the middle of a hold abandons the check
    cur_req = "R1";
    n_pass = 0; n_fail = 0;
    @(negedge clk);
    ctrl_code = 2'd1; phase_nonneg = 1;
    repeat (200) @(negedge clk);
    rst = 1; phase_nonneg = 0;
    @(negedge clk);
    rst = 0;
    check_eq("R1", "fail right after reset", int'(fail_o), 0);
    repeat (1300) @(negedge clk);
    omega_hi = 1;
    repeat (5) @(negedge clk);
    omega_hi = 0;
    check_eq("R1", "pulses after mid-check reset", n_pass + n_fail, 0);

    finish_up();
  end
endmodule